// File: doc/BRIEF.md
# I2C Slave Receive Address Matcher with General Call

This block is the receive front end of an I2C slave. It watches already-synchronised SCL and SDA levels and finds Start, repeated Start and Stop conditions. After a Start it shifts in the first byte and tests it against two addresses: the programmed own address and the fixed general call address, which is all zeros with the direction bit cleared. A byte that is accepted is copied into a holding register for the host. The block then pulls SDA low for the acknowledge bit and raises an interrupt flag when the acknowledge bit ends.

The own address is either 7 bits or 10 bits wide. A 10-bit address arrives as a header byte followed by a byte holding the low eight address bits. When the header matches, the block raises an address-update flag, which tells the host that the second address phase has started. A general call received while 10-bit mode is selected skips that second phase. The update flag stays clear, and every byte after the acknowledge is data. The accepted address byte stays in the holding register, so the host can read it to tell a general call from a device-specific address.

The host sees a buffer-full flag that clears when the host reads the buffer. It also sees an interrupt flag and an overflow flag, and both clear only on an explicit clear strobe. If a byte completes while the buffer is still full, the block keeps the old contents and does not acknowledge the byte.

Top module: `i2c_gc_slave`

## Requirements
- R1: In 7-bit mode, a first byte equal to {ownAddr[6:0], 0} is accepted. A byte with the low bit set, or with any other address, gets no acknowledge and does not load the buffer.
- R2: A first byte of 0x00 is accepted as a general call only while gcEnable is 1. In either addressing mode, 0x00 gets no acknowledge while gcEnable is 0 and no other match applies.
- R3: For an accepted byte, sdaPullDown is 1 from the SCL fall after the eighth bit until the SCL fall that ends the ninth bit. It is 0 during all data bits and for every byte that is not accepted.
- R4: intFlag rises on the SCL fall that ends the ninth bit of an accepted byte. It stays 1 through buffer reads and clears only when intClear is pulsed. If a set and a clear come in the same cycle, the set wins.
- R5: When a byte is accepted, it is copied into rxData and bufFull becomes 1 at the eighth bit. A bufRead pulse clears bufFull, and rxData keeps its value.
- R6: In 10-bit mode, a first byte equal to {11110, ownAddr[9:8], 0} is accepted and sets updAddr. The next byte is accepted only if it equals ownAddr[7:0]. updAddr clears when that second byte completes, or on any Start or Stop.
- R7: In 10-bit mode with gcEnable set, a 0x00 first byte is accepted and updAddr stays 0. The next byte is taken as data (acknowledged and buffered) without being compared with the address.
- R8: After an accepted address phase, every following byte is acknowledged and buffered as data until the next Start or Stop.
- R9: If a byte that would be accepted completes while bufFull is 1, overflow is set. rxData keeps its old value, no acknowledge is given, and later bytes are ignored until a Start. intClear clears overflow.
- R10: A Start or repeated Start (SDA falling while SCL is high) restarts the address search. A Stop (SDA rising while SCL is high) makes the block ignore all bits until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA level |
| ownAddr | input | 10 | Own slave address; the low 7 bits are used in 7-bit mode |
| tenBitMode | input | 1 | 1 selects 10-bit own addressing |
| gcEnable | input | 1 | 1 enables general call recognition |
| bufRead | input | 1 | Host read strobe for the holding buffer |
| intClear | input | 1 | Host strobe that clears intFlag and overflow |
| sdaPullDown | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| rxData | output | 8 | Holding buffer with the last accepted byte |
| bufFull | output | 1 | Holding buffer holds an unread byte |
| intFlag | output | 1 | Interrupt flag |
| overflow | output | 1 | A byte was lost because the buffer was full |
| updAddr | output | 1 | The 10-bit header matched; the second address byte is expected |

## Verification
The bench builds the block with its default widths: a 10-bit own address and 8-bit bytes. It programs the own address to 0x2A5. With that one value, the 7-bit byte 0x4A, the 10-bit header 0xF4 and the low byte 0xA5 can all be reached, and near misses of each can be tried against the same settings. The bench sweeps the mode and general call enable over every first-byte class. This shows a header accepted in one mode and refused in the other, and the general call going straight to data in 10-bit mode. Directed sequences cover the second 10-bit address phase, overflow with the buffer left unread, a repeated Start, and bytes sent after a Stop.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_DATA,
    ST_SKIP
  } i2csState_t;

  typedef struct packed {
    logic shiftEn;
    logic cntClr;
    logic loadBuf;
    logic setOvf;
    logic setUpd;
    logic clrUpd;
    logic pullOn;
    logic pullOff;
    logic raiseInt;
  } i2csStrobe_t;

  localparam logic [4:0] TEN_HDR = 5'b11110;
endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              bufRead,
  input  logic              intClear,
  input  i2csStrobe_t       stb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] newByte,
  output logic              sdaPullDown,
  output logic [BYTE_W-1:0] rxData,
  output logic              bufFull,
  output logic              intFlag,
  output logic              overflow,
  output logic              updAddr
);
  logic sclQ, sdaQ;
  logic [BYTE_W-1:0] shiftReg;

  // bus events from the previous and present line levels
  assign sclRise = sclIn & ~sclQ;
  assign sclFall = ~sclIn & sclQ;
  assign startEv = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopEv  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign newByte = {shiftReg[BYTE_W-2:0], sdaIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      shiftReg <= '0;
      bitCnt <= '0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (stb.cntClr) begin
        bitCnt <= '0;
      end else if (stb.shiftEn) begin
        shiftReg <= newByte;
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= '0;
      bufFull <= 1'b0;
      intFlag <= 1'b0;
      overflow <= 1'b0;
      updAddr <= 1'b0;
      sdaPullDown <= 1'b0;
    end else begin
      if (stb.loadBuf) begin
        rxData <= newByte;
        bufFull <= 1'b1;
      end else if (bufRead) begin
        bufFull <= 1'b0;
      end
      if (stb.raiseInt) intFlag <= 1'b1;
      else if (intClear) intFlag <= 1'b0;
      if (stb.setOvf) overflow <= 1'b1;
      else if (intClear) overflow <= 1'b0;
      if (stb.setUpd) updAddr <= 1'b1;
      else if (stb.clrUpd) updAddr <= 1'b0;
      if (stb.pullOff) sdaPullDown <= 1'b0;
      else if (stb.pullOn) sdaPullDown <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] newByte,
  input  logic              bufFull,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              gcEnable,
  output i2csStrobe_t       stb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);

  i2csState_t state, pendSt, nextSt;
  logic inAck, ackGo;
  logic active, shiftNow, byteEnd, ackEdge, ackDone;
  logic gcHit, own7Hit, own10Hit, match, accept;

  assign active   = (state == ST_ADDR1) || (state == ST_ADDR2) || (state == ST_DATA);
  assign shiftNow = sclRise && active && (bitCnt < ACK_BIT);
  assign byteEnd  = shiftNow && (bitCnt == LAST_BIT);
  assign ackEdge  = sclFall && (bitCnt == ACK_BIT) && !inAck;
  assign ackDone  = sclFall && inAck;

  assign gcHit    = gcEnable && (newByte == '0);
  assign own7Hit  = !tenBitMode && (newByte == {ownAddr[6:0], 1'b0});
  assign own10Hit = tenBitMode &&
                    (newByte == {TEN_HDR, ownAddr[ADDR_W-1:ADDR_W-2], 1'b0});

  always_comb begin
    match  = 1'b0;
    nextSt = ST_SKIP;
    unique case (state)
      ST_ADDR1: begin
        match = gcHit || own7Hit || own10Hit;
        if (gcHit || own7Hit) nextSt = ST_DATA;
        else if (own10Hit) nextSt = ST_ADDR2;
      end
      ST_ADDR2: begin
        match = (newByte == ownAddr[BYTE_W-1:0]);
        nextSt = ST_DATA;
      end
      ST_DATA: begin
        match = 1'b1;
        nextSt = ST_DATA;
      end
      default: ;
    endcase
    accept = match && !bufFull;
    if (!accept) nextSt = ST_SKIP;
  end

  always_comb begin
    stb.shiftEn  = shiftNow;
    stb.cntClr   = ackDone || startEv || stopEv;
    stb.loadBuf  = byteEnd && accept;
    stb.setOvf   = byteEnd && match && bufFull;
    stb.setUpd   = byteEnd && accept && (state == ST_ADDR1) && own10Hit && !gcHit;
    stb.clrUpd   = (byteEnd && (state == ST_ADDR2)) || startEv || stopEv;
    stb.pullOn   = ackEdge && ackGo;
    stb.pullOff  = ackDone || startEv || stopEv;
    stb.raiseInt = ackDone && ackGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pendSt <= ST_IDLE;
      inAck  <= 1'b0;
      ackGo  <= 1'b0;
    end else if (startEv) begin
      state <= ST_ADDR1;
      inAck <= 1'b0;
      ackGo <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE;
      inAck <= 1'b0;
      ackGo <= 1'b0;
    end else if (byteEnd) begin
      ackGo  <= accept;
      pendSt <= nextSt;
    end else if (ackEdge) begin
      inAck <= 1'b1;
    end else if (ackDone) begin
      inAck <= 1'b0;
      ackGo <= 1'b0;
      state <= pendSt;
    end
  end
endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              gcEnable,
  input  logic              bufRead,
  input  logic              intClear,
  output logic              sdaPullDown,
  output logic [BYTE_W-1:0] rxData,
  output logic              bufFull,
  output logic              intFlag,
  output logic              overflow,
  output logic              updAddr
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  i2csStrobe_t stb;
  logic sclRise, sclFall, startEv, stopEv;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] newByte;

  i2cs_datapath #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .bufRead(bufRead), .intClear(intClear), .stb(stb),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .bitCnt(bitCnt), .newByte(newByte), .sdaPullDown(sdaPullDown),
    .rxData(rxData), .bufFull(bufFull), .intFlag(intFlag),
    .overflow(overflow), .updAddr(updAddr)
  );

  i2cs_control #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .bitCnt(bitCnt), .newByte(newByte),
    .bufFull(bufFull), .ownAddr(ownAddr), .tenBitMode(tenBitMode),
    .gcEnable(gcEnable), .stb(stb)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              tenBitMode,
  input logic              bufRead,
  input logic              intClear,
  input logic              sdaPullDown,
  input logic [BYTE_W-1:0] rxData,
  input logic              bufFull,
  input logic              intFlag,
  input logic              overflow,
  input logic              updAddr
);
  // R3
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> !sclIn);

  // R4
  int_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> ($past(sclIn) == 1'b0 && $past(sclIn, 2) == 1'b1));

  // R4
  int_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intFlag) |-> $past(intClear));

  // R5
  full_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufFull) |-> $past(bufRead));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $stable(rxData));

  // R6
  upd_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updAddr) |-> $past(tenBitMode));
endmodule

bind i2c_gc_slave i2cs_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .tenBitMode(tenBitMode),
  .bufRead(bufRead), .intClear(intClear), .sdaPullDown(sdaPullDown),
  .rxData(rxData), .bufFull(bufFull), .intFlag(intFlag),
  .overflow(overflow), .updAddr(updAddr)
);

// File: tb/sim_i2c_gc_slave.sv
module sim_i2c_gc_slave;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] OWN = 10'h2A5;
  localparam int NVEC = 11;
  // fields: [11:4] first byte, [3] tenBit, [2] gcEnable, [1] ack expected, [0] updAddr expected
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h4A, 4'b0010}, {8'h4B, 4'b0000}, {8'h4C, 4'b0000}, {8'h00, 4'b0110},
    {8'h00, 4'b0000}, {8'hF4, 4'b1011}, {8'hF4, 4'b0000}, {8'h4A, 4'b1000},
    {8'h00, 4'b1110}, {8'hF6, 4'b1000}, {8'h00, 4'b1000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic tenBitMode = 1'b0, gcEnable = 1'b0, bufRead = 1'b0, intClear = 1'b0;
  logic sdaPullDown, bufFull, intFlag, overflow, updAddr;
  logic [7:0] rxData;
  logic sdaLine;
  logic lastAck, lastGlitch;
  int checks = 0, fails = 0;
  bit done = 0;

  assign sdaLine = sdaDrv & ~sdaPullDown;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_gc_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .ownAddr(OWN),
    .tenBitMode(tenBitMode), .gcEnable(gcEnable), .bufRead(bufRead),
    .intClear(intClear), .sdaPullDown(sdaPullDown), .rxData(rxData),
    .bufFull(bufFull), .intFlag(intFlag), .overflow(overflow), .updAddr(updAddr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic lowAck;
    lastGlitch = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ();
      if (sdaPullDown) lastGlitch = 1'b1;
      sclDrv = 1'b1; waitQ();
      if (sdaPullDown) lastGlitch = 1'b1;
      sclDrv = 1'b0;
    end
    sdaDrv = 1'b1; waitQ();
    lowAck = sdaPullDown;
    sclDrv = 1'b1; waitQ();
    lastAck = lowAck & sdaPullDown;
    if (lowAck != sdaPullDown) lastGlitch = 1'b1;
    sclDrv = 1'b0; waitQ();
    if (sdaPullDown) lastGlitch = 1'b1;
  endtask

  task automatic hostRead();
    @(negedge clk) bufRead = 1'b1;
    @(negedge clk) bufRead = 1'b0;
  endtask

  task automatic hostClear();
    @(negedge clk) intClear = 1'b1;
    @(negedge clk) intClear = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 reset bufFull", 16'(bufFull), 16'h0);
    check("R4 reset intFlag", 16'(intFlag), 16'h0);
    check("R3 reset sdaPullDown", 16'(sdaPullDown), 16'h0);
    check("R9 reset overflow", 16'(overflow), 16'h0);
    check("R6 reset updAddr", 16'(updAddr), 16'h0);
    check("R5 reset rxData", 16'(rxData), 16'h0);

    // table walk over first-byte classes and modes
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] b;
      logic expAck, expUpd;
      b = VEC[v][11:4];
      tenBitMode = VEC[v][3];
      gcEnable = VEC[v][2];
      expAck = VEC[v][1];
      expUpd = VEC[v][0];
      busStart();
      sendByte(b);
      check($sformatf("R1/R2/R6 ack vec%0d", v), 16'(lastAck), 16'(expAck));
      check($sformatf("R3 ack window vec%0d", v), 16'(lastGlitch), 16'h0);
      check($sformatf("R5 bufFull vec%0d", v), 16'(bufFull), 16'(expAck));
      check($sformatf("R6/R7 updAddr vec%0d", v), 16'(updAddr), 16'(expUpd));
      if (expAck) begin
        check($sformatf("R5 rxData vec%0d", v), 16'(rxData), 16'(b));
        check($sformatf("R4 intFlag set vec%0d", v), 16'(intFlag), 16'h1);
        hostRead();
        check($sformatf("R5 bufFull cleared vec%0d", v), 16'(bufFull), 16'h0);
        check($sformatf("R4 intFlag held vec%0d", v), 16'(intFlag), 16'h1);
        hostClear();
        check($sformatf("R4 intFlag cleared vec%0d", v), 16'(intFlag), 16'h0);
      end else begin
        check($sformatf("R4 no int vec%0d", v), 16'(intFlag), 16'h0);
      end
      busStop();
      check($sformatf("R6 updAddr after stop vec%0d", v), 16'(updAddr), 16'h0);
    end

    // 10-bit full address then data
    tenBitMode = 1'b1; gcEnable = 1'b0;
    busStart();
    sendByte(8'hF4);
    check("R6 header ack", 16'(lastAck), 16'h1);
    check("R6 updAddr set", 16'(updAddr), 16'h1);
    hostRead(); hostClear();
    sendByte(8'hA5);
    check("R6 low byte ack", 16'(lastAck), 16'h1);
    check("R6 updAddr cleared", 16'(updAddr), 16'h0);
    check("R6 low byte buffered", 16'(rxData), 16'hA5);
    hostRead();
    sendByte(8'h3C);
    check("R8 10-bit data ack", 16'(lastAck), 16'h1);
    check("R8 10-bit data value", 16'(rxData), 16'h3C);
    hostRead(); hostClear();
    busStop();

    // 10-bit wrong low byte
    busStart();
    sendByte(8'hF4);
    hostRead(); hostClear();
    sendByte(8'hA6);
    check("R6 wrong low byte nack", 16'(lastAck), 16'h0);
    check("R6 wrong low byte no load", 16'(bufFull), 16'h0);
    check("R6 updAddr clear after mismatch", 16'(updAddr), 16'h0);
    busStop();

    // general call in 10-bit mode goes straight to data
    gcEnable = 1'b1;
    busStart();
    sendByte(8'h00);
    check("R7 gc ack", 16'(lastAck), 16'h1);
    check("R7 no updAddr", 16'(updAddr), 16'h0);
    check("R7 gc byte in buffer", 16'(rxData), 16'h00);
    hostRead(); hostClear();
    sendByte(8'h55);
    check("R7 data after gc ack", 16'(lastAck), 16'h1);
    check("R7 data after gc value", 16'(rxData), 16'h55);
    hostRead(); hostClear();
    busStop();

    // overflow in 7-bit mode
    tenBitMode = 1'b0; gcEnable = 1'b0;
    busStart();
    sendByte(8'h4A);
    check("R1 own7 ack before overflow", 16'(lastAck), 16'h1);
    sendByte(8'h11);
    check("R9 overflow nack", 16'(lastAck), 16'h0);
    check("R9 overflow set", 16'(overflow), 16'h1);
    check("R9 buffer kept", 16'(rxData), 16'h4A);
    hostRead();
    sendByte(8'h22);
    check("R9 bytes ignored after overflow", 16'(lastAck), 16'h0);
    check("R9 buffer still kept", 16'(bufFull), 16'h0);
    busStop();
    hostClear();
    check("R9 overflow cleared", 16'(overflow), 16'h0);
    check("R4 intFlag cleared after overflow", 16'(intFlag), 16'h0);

    // repeated start re-hunts for an address
    busStart();
    sendByte(8'h4A);
    hostRead(); hostClear();
    busStart();
    sendByte(8'h4C);
    check("R10 repeated start re-hunt nack", 16'(lastAck), 16'h0);
    check("R10 buffer after re-hunt", 16'(rxData), 16'h4A);
    sendByte(8'h4A);
    check("R10 skip until next start", 16'(lastAck), 16'h0);
    busStart();
    sendByte(8'h4A);
    check("R10 repeated start own address", 16'(lastAck), 16'h1);
    hostRead(); hostClear();
    busStop();

    // bytes after stop without start are ignored
    sclDrv = 1'b0; waitQ();
    sendByte(8'h4A);
    check("R10 idle after stop nack", 16'(lastAck), 16'h0);
    check("R10 idle after stop no load", 16'(bufFull), 16'h0);
    check("R10 idle after stop no int", 16'(intFlag), 16'h0);
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule